// File: doc/BRIEF.md
# Debug Handshake Gate for a Valid/Ready Channel

This block sits in series on one valid/ready channel, between an IP port and the local bus that serves it. While running, it is transparent: data, the last-word flag and both handshake signals pass straight through in the same cycle. Under debug control it closes the channel by holding downstream valid and upstream ready low together, so that no transfer can complete. A closed channel stays frozen until a debugger lets it go, either for one unit of traffic or with no limit.

The gate stops at one of two granularities. At word granularity it stops after any single handshake. At message granularity it stops only on a message boundary, which the last-word flag marks. A stop can come from a command written by software or from a broadcast debug event pulse, depending on the action mode. Configuration and commands arrive over a small write-only register interface. A status word reports the configuration, whether the gate is stopped, whether it has left the stopped state since it was last released, whether the channel is idle while stopped, whether a request message is partly transferred, and whether responses are outstanding. A saturating counter tracks the outstanding responses: it counts completed request messages and subtracts completed response messages, which the block observes on a separate response handshake.

Top module: `hs_gate_shim`

## Requirements
- R1: While the gate is open, dnValid equals upValid, upReady equals dnReady, and dnData and dnLast equal upData and upLast in the same cycle, with words delivered in order.
- R2: While the stopped status bit is 1, dnValid and upReady are both 0.
- R3: At word granularity (config bit 1 = 0), an accepted stop request sets the stopped bit at the clock edge that samples the request.
- R4: At message granularity (config bit 1 = 1), a stop requested after some words of a message have passed leaves the gate open until the handshake of the word with the last flag set. The stopped bit then rises at that edge, and no word of the following message passes.
- R5: The mode is held in config bits 3:2. In mode 00 (passive), stop, step and run commands and event pulses are all ignored. In mode 01 (immediate), a stop command acts but an event pulse is ignored. In mode 10 (event-driven), an event pulse stops the gate. Step and run commands act in modes 01 and 10.
- R6: When config bit 0 (stop enable) is 0, neither stop commands nor event pulses stop the gate.
- R7: A step command (command bit 1) given while stopped opens the gate for exactly one unit, which is one word at word granularity or one whole message at message granularity. The gate then stops again by itself.
- R8: A run command (command bit 2) given while stopped opens the gate until the next stop, whatever number of words pass.
- R9: A write to cfgAddr 0 loads the configuration {mode[3:2], granularity[1], stopEnable[0]}. A write to cfgAddr 1 is a command: bit 0 stop, bit 1 step, bit 2 run, bit 3 clear. The left-stop bit is set when a step or run leaves the stopped state, and a clear command resets it in any mode.
- R10: The status word is {pending[8], inProgress[7], quiescent[6], leftStop[5], stopped[4], mode[3:2], granularity[1], stopEnable[0]}. Quiescent is 1 exactly when the gate is stopped and upValid is 0.
- R11: inProgress is 1 after a request word without the last flag has passed, and it returns to 0 after the last word. pendCount rises by one for each request message that completes and falls by one for each response handshake that carries the last flag. It saturates at its maximum and at zero, and pending is 1 when pendCount is not zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| upValid | input | 1 | Valid from the channel source |
| upReady | output | 1 | Gated ready back to the source |
| upData | input | DATA_W | Word from the source |
| upLast | input | 1 | Last word of a message, from the source |
| dnValid | output | 1 | Gated valid to the sink |
| dnReady | input | 1 | Ready from the sink |
| dnData | output | DATA_W | Word to the sink |
| dnLast | output | 1 | Last-word flag to the sink |
| rspValid | input | 1 | Observed response valid |
| rspReady | input | 1 | Observed response ready |
| rspLast | input | 1 | Observed response last-word flag |
| evtPulse | input | 1 | Broadcast debug event pulse |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 1 | 0 selects configuration, 1 selects command |
| cfgWrData | input | 4 | Register write data |
| statusWord | output | 9 | Status and configuration readback |
| pendCount | output | CNT_W | Outstanding response count |

## Verification
The bench goes after the case where a stop arrives in the middle of a message at message granularity. A gate that ignored the boundary would cut the message short, and a gate that ignored the stop would let the next message through as well. It also checks that a single step releases exactly one unit and closes again. A faulty gate here would stay open or release a word too many. Mode and enable filtering are exercised with commands and events that must have no effect, where a wrong decode would freeze traffic. The outstanding counter is driven past both of its limits, where a wrong counter would wrap to zero or to its maximum.

// File: rtl/hsg_pkg.sv
package hsg_pkg;

  localparam int CFG_W  = 4;
  localparam int STAT_W = 9;

  localparam int S_STOPEN  = 0;
  localparam int S_GRAN    = 1;
  localparam int S_MODE_LO = 2;
  localparam int S_STOPPED = 4;
  localparam int S_LEFT    = 5;
  localparam int S_QUIET   = 6;
  localparam int S_INPROG  = 7;
  localparam int S_PEND    = 8;

  localparam logic [1:0] MODE_PASSIVE = 2'b00;
  localparam logic [1:0] MODE_NOW     = 2'b01;
  localparam logic [1:0] MODE_EVENT   = 2'b10;

  typedef enum logic [1:0] {
    ST_RUN  = 2'b00,
    ST_HALT = 2'b01,
    ST_STEP = 2'b10
  } gateState_e;

  // control -> datapath
  typedef struct packed {
    logic gateOpen;
  } ctlStrobes_t;

  // datapath -> control
  typedef struct packed {
    logic elemDone;
    logic msgDone;
    logic midMsg;
  } dpEvents_t;

endpackage

// File: rtl/hsg_datapath.sv
module hsg_datapath
  import hsg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       ctl,
  input  logic              upValid,
  output logic              upReady,
  input  logic [DATA_W-1:0] upData,
  input  logic              upLast,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [DATA_W-1:0] dnData,
  output logic              dnLast,
  input  logic              rspValid,
  input  logic              rspReady,
  input  logic              rspLast,
  output dpEvents_t         ev,
  output logic [CNT_W-1:0]  pendCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic midMsgQ;
  logic [CNT_W-1:0] cntQ;
  logic elemDone, msgDone, rspDone;

  // gating: both directions of the handshake closed together
  assign dnValid = upValid & ctl.gateOpen;
  assign upReady = dnReady & ctl.gateOpen;
  assign dnData  = upData;
  assign dnLast  = upLast;

  assign elemDone = upValid & dnReady & ctl.gateOpen;
  assign msgDone  = elemDone & upLast;
  assign rspDone  = rspValid & rspReady & rspLast;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      midMsgQ <= 1'b0;
    end else if (msgDone) begin
      midMsgQ <= 1'b0;
    end else if (elemDone) begin
      midMsgQ <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else begin
      unique case ({msgDone, rspDone})
        2'b10:   if (cntQ != CNT_MAX) cntQ <= cntQ + 1'b1;
        2'b01:   if (cntQ != '0)      cntQ <= cntQ - 1'b1;
        default: cntQ <= cntQ;
      endcase
    end
  end

  assign ev.elemDone = elemDone;
  assign ev.msgDone  = msgDone;
  assign ev.midMsg   = midMsgQ;
  assign pendCount   = cntQ;

  // R11: counter never wraps upward
  a_r11_sat_high: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == CNT_MAX && msgDone && !rspDone) |=> pendCount == CNT_MAX);

  // R11: counter never wraps downward
  a_r11_sat_low: assert property (@(posedge clk) disable iff (!rstN)
    (pendCount == '0 && rspDone && !msgDone) |=> pendCount == '0);

  // R11: message end clears the in-progress flag
  a_r11_mid_clear: assert property (@(posedge clk) disable iff (!rstN)
    msgDone |=> !ev.midMsg);

endmodule

// File: rtl/hsg_control.sv
module hsg_control
  import hsg_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgAddr,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             evtPulse,
  input  logic             upValid,
  input  dpEvents_t        ev,
  output ctlStrobes_t      ctl,
  output logic             stopEn,
  output logic             granMsg,
  output logic [1:0]       mode,
  output logic             stopped,
  output logic             leftStop,
  output logic             quiescent
);

  logic       stopEnQ, granMsgQ, stopPendQ, leftQ;
  logic [1:0] modeQ;
  gateState_e stateQ;

  gateState_e stateD;
  logic       pendD, leftD;

  logic cfgWr, cmdWr, modeNow, modeEvt, active;
  logic newStop, stepCmd, runCmd, clrCmd;
  logic unitDone, atBoundary, stopWant;

  assign cfgWr   = cfgWrEn & ~cfgAddr;
  assign cmdWr   = cfgWrEn &  cfgAddr;
  assign modeNow = (modeQ == MODE_NOW);
  assign modeEvt = (modeQ == MODE_EVENT);
  assign active  = modeNow | modeEvt;

  assign newStop = stopEnQ & ((modeEvt & evtPulse) | (modeNow & cmdWr & cfgWrData[0]));
  assign stepCmd = active & cmdWr & cfgWrData[1];
  assign runCmd  = active & cmdWr & cfgWrData[2];
  assign clrCmd  = cmdWr & cfgWrData[3];

  assign unitDone   = granMsgQ ? ev.msgDone : ev.elemDone;
  // a stop may land here without splitting a message
  assign atBoundary = ~granMsgQ | ev.msgDone | (~ev.midMsg & ~ev.elemDone);
  assign stopWant   = stopPendQ | newStop;

  always_comb begin
    stateD = stateQ;
    pendD  = stopPendQ;
    leftD  = clrCmd ? 1'b0 : leftQ;
    unique case (stateQ)
      ST_RUN, ST_STEP: begin
        if (stopWant && atBoundary) begin
          stateD = ST_HALT;
          pendD  = 1'b0;
        end else begin
          if (stopWant) pendD = 1'b1;
          if (stateQ == ST_STEP && unitDone) begin
            stateD = ST_HALT;
            pendD  = 1'b0;
          end
        end
      end
      ST_HALT: begin
        pendD = 1'b0;
        if (runCmd) begin
          stateD = ST_RUN;
          leftD  = 1'b1;
        end else if (stepCmd) begin
          stateD = ST_STEP;
          leftD  = 1'b1;
        end
      end
      default: stateD = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stopEnQ   <= 1'b0;
      granMsgQ  <= 1'b0;
      modeQ     <= MODE_PASSIVE;
      stateQ    <= ST_RUN;
      stopPendQ <= 1'b0;
      leftQ     <= 1'b0;
    end else begin
      if (cfgWr) begin
        stopEnQ  <= cfgWrData[0];
        granMsgQ <= cfgWrData[1];
        modeQ    <= cfgWrData[3:2];
      end
      stateQ    <= stateD;
      stopPendQ <= pendD;
      leftQ     <= leftD;
    end
  end

  assign stopped      = (stateQ == ST_HALT);
  assign ctl.gateOpen = ~stopped;
  assign quiescent    = stopped & ~upValid;
  assign stopEn       = stopEnQ;
  assign granMsg      = granMsgQ;
  assign mode         = modeQ;
  assign leftStop     = leftQ;

  // R7: a released unit closes the gate again
  a_r7_step_restops: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STEP && unitDone) |=> stopped);

  // R4: entering stop at message granularity never splits a message
  a_r4_msg_boundary: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(stopped) && $past(granMsgQ)) |-> !ev.midMsg);

  // R5: passive mode keeps a running gate running
  a_r5_passive_hold: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == MODE_PASSIVE && stateQ == ST_RUN && !stopPendQ) |=> stateQ == ST_RUN);

  // R6: disabled stop keeps a running gate running
  a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stopEnQ && stateQ == ST_RUN && !stopPendQ) |=> stateQ == ST_RUN);

  // R9: left-stop only rises when leaving the stopped state
  a_r9_left_from_halt: assert property (@(posedge clk) disable iff (!rstN)
    $rose(leftQ) |-> $past(stateQ) == ST_HALT);

endmodule

// File: rtl/hs_gate_shim.sv
module hs_gate_shim
  import hsg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              upValid,
  output logic              upReady,
  input  logic [DATA_W-1:0] upData,
  input  logic              upLast,
  output logic              dnValid,
  input  logic              dnReady,
  output logic [DATA_W-1:0] dnData,
  output logic              dnLast,
  input  logic              rspValid,
  input  logic              rspReady,
  input  logic              rspLast,
  input  logic              evtPulse,
  input  logic              cfgWrEn,
  input  logic              cfgAddr,
  input  logic [CFG_W-1:0]  cfgWrData,
  output logic [STAT_W-1:0] statusWord,
  output logic [CNT_W-1:0]  pendCount
);

  ctlStrobes_t ctl;
  dpEvents_t   ev;
  logic        stopEn, granMsg, stopped, leftStop, quiescent;
  logic [1:0]  mode;

  hsg_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .evtPulse  (evtPulse),
    .upValid   (upValid),
    .ev        (ev),
    .ctl       (ctl),
    .stopEn    (stopEn),
    .granMsg   (granMsg),
    .mode      (mode),
    .stopped   (stopped),
    .leftStop  (leftStop),
    .quiescent (quiescent)
  );

  hsg_datapath #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .upValid   (upValid),
    .upReady   (upReady),
    .upData    (upData),
    .upLast    (upLast),
    .dnValid   (dnValid),
    .dnReady   (dnReady),
    .dnData    (dnData),
    .dnLast    (dnLast),
    .rspValid  (rspValid),
    .rspReady  (rspReady),
    .rspLast   (rspLast),
    .ev        (ev),
    .pendCount (pendCount)
  );

  always_comb begin
    statusWord                         = '0;
    statusWord[S_STOPEN]               = stopEn;
    statusWord[S_GRAN]                 = granMsg;
    statusWord[S_MODE_LO+1:S_MODE_LO]  = mode;
    statusWord[S_STOPPED]              = stopped;
    statusWord[S_LEFT]                 = leftStop;
    statusWord[S_QUIET]                = quiescent;
    statusWord[S_INPROG]               = ev.midMsg;
    statusWord[S_PEND]                 = (pendCount != '0);
  end

  // R2: no transfer can complete while stopped
  a_r2_closed_when_stopped: assert property (@(posedge clk) disable iff (!rstN)
    statusWord[S_STOPPED] |-> (!dnValid && !upReady));

endmodule

// File: tb/hs_gate_shim_tb.sv
module hs_gate_shim_tb;

  localparam int DW = 16;
  localparam int CW = 4;
  localparam int PMAX = 15;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic upValid = 1'b0, upLast = 1'b0, dnReady = 1'b1;
  logic [DW-1:0] upData = '0;
  logic upReady, dnValid, dnLast;
  logic [DW-1:0] dnData;
  logic rspValid = 1'b0, rspReady = 1'b0, rspLast = 1'b0;
  logic evtPulse = 1'b0, cfgWrEn = 1'b0, cfgAddr = 1'b0;
  logic [3:0] cfgWrData = '0;
  logic [8:0] statusWord;
  logic [CW-1:0] pendCount;

  always #5 clk = ~clk;

  hs_gate_shim #(.DATA_W(DW), .CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN),
    .upValid(upValid), .upReady(upReady), .upData(upData), .upLast(upLast),
    .dnValid(dnValid), .dnReady(dnReady), .dnData(dnData), .dnLast(dnLast),
    .rspValid(rspValid), .rspReady(rspReady), .rspLast(rspLast),
    .evtPulse(evtPulse), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .statusWord(statusWord), .pendCount(pendCount)
  );

  typedef struct { logic [DW-1:0] d; logic l; } word_t;
  word_t sendQ[$];
  word_t expQ[$];

  int nChecks = 0, nFails = 0, dnCount = 0, tbPend = 0;
  bit done = 1'b0;

  task automatic check(string req, string what, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // source: presents the head of sendQ, pops it after each handshake
  initial begin
    forever begin
      bit hs;
      @(negedge clk);
      hs = upValid && upReady;
      @(posedge clk);
      #1;
      if (hs && sendQ.size() > 0) void'(sendQ.pop_front());
      if (sendQ.size() > 0) begin
        upValid = 1'b1; upData = sendQ[0].d; upLast = sendQ[0].l;
      end else begin
        upValid = 1'b0; upLast = 1'b0;
      end
    end
  end

  // monitor: scoreboard compare of every downstream handshake (R1)
  always @(negedge clk) begin
    if (rstN && dnValid && dnReady) begin
      if (expQ.size() == 0) begin
        check("R1", "unexpected word", 1, 0);
      end else begin
        word_t e;
        e = expQ.pop_front();
        check("R1", "data", int'(dnData), int'(e.d));
        check("R1", "last", int'(dnLast), int'(e.l));
      end
      dnCount++;
      if (dnLast && tbPend < PMAX) tbPend++;
    end
  end

  task automatic tick(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic regWrite(logic a, logic [3:0] d);
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    tick(1);
    cfgWrEn = 1'b0;
  endtask

  function automatic logic [3:0] cfgWord(logic en, logic gm, logic [1:0] m);
    return {m, gm, en};
  endfunction

  task automatic pushWord(logic [DW-1:0] d, logic l);
    word_t w;
    w.d = d; w.l = l;
    sendQ.push_back(w);
    expQ.push_back(w);
  endtask

  task automatic pulseEvt();
    evtPulse = 1'b1; tick(1); evtPulse = 1'b0;
  endtask

  task automatic rspPulse();
    rspValid = 1'b1; rspReady = 1'b1; rspLast = 1'b1;
    tick(1);
    rspValid = 1'b0; rspReady = 1'b0; rspLast = 1'b0;
    if (tbPend > 0) tbPend--;
  endtask

  function automatic int stBit(int i);
    return int'(statusWord[i]);
  endfunction

  initial begin
    #1_000_000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    tick(4);
    rstN = 1'b1;
    tick(1);
    // reset state
    check("R10", "status after reset", int'(statusWord), 0);
    check("R11", "pendCount after reset", int'(pendCount), 0);
    check("R2", "dnValid idle", int'(dnValid), 0);

    // R1: pass-through of two messages
    pushWord(16'h1001, 0); pushWord(16'h1002, 0); pushWord(16'h1003, 1);
    pushWord(16'h2001, 1);
    tick(8);
    check("R1", "words delivered", dnCount, 4);
    pushWord(16'h3001, 1);
    dnReady = 1'b0;
    tick(2);
    check("R1", "dnValid follows upValid", int'(dnValid), 1);
    check("R1", "upReady follows dnReady", int'(upReady), 0);
    dnReady = 1'b1;
    tick(3);
    check("R1", "held word delivered", dnCount, 5);

    // R5: passive ignores commands and events
    regWrite(0, cfgWord(1, 0, 2'b00));
    regWrite(1, 4'b0001);
    pulseEvt();
    tick(1);
    check("R5", "passive not stopped", stBit(4), 0);

    // R6: stop disabled
    regWrite(0, cfgWord(0, 0, 2'b10));
    pulseEvt();
    regWrite(0, cfgWord(0, 0, 2'b01));
    regWrite(1, 4'b0001);
    tick(1);
    check("R6", "disabled not stopped", stBit(4), 0);

    // R5: immediate mode ignores event
    regWrite(0, cfgWord(1, 0, 2'b01));
    pulseEvt();
    tick(1);
    check("R5", "immediate ignores event", stBit(4), 0);

    // R3: event mode, word granularity
    regWrite(0, cfgWord(1, 0, 2'b10));
    pulseEvt();
    check("R3", "stopped at event edge", stBit(4), 1);
    check("R10", "quiescent idle stop", stBit(6), 1);
    pushWord(16'h4001, 0); pushWord(16'h4002, 0); pushWord(16'h4003, 1);
    tick(5);
    check("R2", "no words while stopped", dnCount, 5);
    check("R2", "dnValid low", int'(dnValid), 0);
    check("R2", "upReady low", int'(upReady), 0);
    check("R10", "not quiescent with valid", stBit(6), 0);

    // R7: word step
    regWrite(1, 4'b0010);
    tick(5);
    check("R7", "one word stepped", dnCount, 6);
    check("R7", "stopped again", stBit(4), 1);
    check("R9", "left stop set", stBit(5), 1);
    check("R11", "in progress", stBit(7), 1);

    // R9: clear and field layout
    regWrite(1, 4'b1000);
    check("R9", "left stop cleared", stBit(5), 0);
    check("R10", "config fields", int'(statusWord[3:0]), 4'b1001);

    // R8: run unbounded
    regWrite(1, 4'b0100);
    tick(6);
    check("R8", "drained", dnCount, 8);
    check("R8", "running", stBit(4), 0);
    check("R9", "left after run", stBit(5), 1);
    for (int i = 0; i < 5; i++) pushWord(16'h5000 + DW'(i), 1);
    tick(10);
    check("R8", "unbounded flow", dnCount, 13);

    // R4: mid-message stop at message granularity
    regWrite(0, cfgWord(1, 0, 2'b01));
    regWrite(1, 4'b0001);
    pushWord(16'h6001, 0); pushWord(16'h6002, 0); pushWord(16'h6003, 0);
    pushWord(16'h6004, 1);
    pushWord(16'h7001, 0); pushWord(16'h7002, 1);
    tick(2);
    regWrite(1, 4'b0010); tick(3);
    regWrite(1, 4'b0010); tick(3);
    check("R4", "two words before switch", dnCount, 15);
    regWrite(0, cfgWord(1, 1, 2'b01));
    dnReady = 1'b0;
    regWrite(1, 4'b0100);
    tick(1);
    regWrite(1, 4'b0001);
    tick(1);
    check("R4", "stop deferred mid-message", stBit(4), 0);
    check("R11", "in progress mid-message", stBit(7), 1);
    dnReady = 1'b1;
    tick(6);
    check("R4", "message finished then stop", dnCount, 17);
    check("R4", "stopped at boundary", stBit(4), 1);
    check("R11", "no longer in progress", stBit(7), 0);

    // R7: message step
    regWrite(1, 4'b0010);
    tick(6);
    check("R7", "one message stepped", dnCount, 19);
    check("R7", "stopped after message", stBit(4), 1);

    // R11: pending counter
    check("R11", "pending count", int'(pendCount), tbPend);
    check("R11", "pending bit", stBit(8), 1);
    rspPulse(); rspPulse();
    tick(1);
    check("R11", "after responses", int'(pendCount), tbPend);
    regWrite(1, 4'b0100);
    for (int i = 0; i < 8; i++) pushWord(16'h8000 + DW'(i), 1);
    tick(14);
    check("R11", "saturated high", int'(pendCount), PMAX);
    for (int i = 0; i < 16; i++) rspPulse();
    tick(1);
    check("R11", "saturated low", int'(pendCount), 0);
    check("R11", "pending bit clear", stBit(8), 0);
    check("R1", "scoreboard empty", expQ.size(), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule